// File: doc/BRIEF.md
# I2C Master Byte Command Engine

This block drives an I2C bus as a master, one bus event at a time. Software writes a control word to request a bus condition (start, repeated start or stop), or writes a data byte to shift eight bits out and clock in the target's acknowledge. Each event runs to completion on its own, reports completion in a status word, and leaves the bus lines where the protocol needs them for the next event. The next event can then follow straight away.

Both lines are open-drain. The outputs are active-low drive enables: 0 pulls the line low, and 1 releases it. A pad-disable input releases both lines regardless of the engine's internal state. Bus timing is built from a step period of `div_i + 1` clock cycles. SDA follows its target level one clock after SCL, so a data change never coincides with an SCL edge.

Register writes use a simple strobe, `wr_en_i`, with a select and a data byte. Select 0 writes the control word, select 1 writes the data byte, and select 2 writes the status word with write-one-to-clear behaviour.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `ctrl_o` and `status_o` read 0 and both drive enables are 1 (released).
- R2: Control word fields are: bit 0 enable; bits 2:1 command (0 none, 1 start/restart, 2 stop, 3 no action); bit 3 condition select. A command starts only when the same write has bit 0 set. Command 0 with enable set leaves the engine idle, and `ctrl_o` then reads 0x01.
- R3: Command 1 with bit 3 = 0 lets SDA fall while SCL is high, then pulls SCL low, in 3 step periods. With bit 3 = 1, the sequence first holds SCL low with SDA released, then releases SCL, then lets SDA fall, then pulls SCL low, in 4 step periods.
- R4: Command 2 holds SDA low, releases SCL, then releases SDA while SCL is high, in 3 step periods. Both lines end released.
- R5: A data write while enabled shifts the byte out MSB first, one bit per SCL rising edge. SDA is released for a ninth clock, and SCL is then held low. The whole byte takes 19 step periods.
- R6: The acknowledge is sampled at the end of the ninth clock's high phase. Control bit 3 then reads 1 for a NAK and 0 for an ACK, and status bit 0 sets on a NAK.
- R7: Status bit 3 sets in the cycle the event completes. Status bit 7 reads 1 from the cycle after the accepting write until that completion cycle.
- R8: A status write with select 2 clears each bit written as 1 and leaves bits written as 0 unchanged. A set in the same cycle wins over the clear.
- R9: Control and data writes made while busy are ignored.
- R10: One step period lasts `div_i + 1` clock cycles.
- R11: During a byte, SDA changes only while SCL is low.
- R12: While `pad_dis_i` is 1, both drive enables stay 1.
- R13: A data write while enable is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 data, 2 status |
| wr_data_i | input | 8 | Write data |
| div_i | input | DIV_W | Step period minus one, in clock cycles |
| pad_dis_i | input | 1 | Release both bus lines |
| sda_i | input | 1 | SDA line level as seen on the pad |
| ctrl_o | output | 8 | Control word readback |
| status_o | output | 8 | Status word |
| scl_drv_n_o | output | 1 | SCL drive enable, 0 pulls low |
| sda_drv_n_o | output | 1 | SDA drive enable, 0 pulls low |

## Verification
The assertions assume that `div_i` is at least 1 and that it changes only while the engine is idle. The one-clock SDA lag needs a low phase of two or more cycles to stay clear of the SCL edges. The stimulus draws each divider value from 1 to 5 and changes it only between events, once busy has been seen to fall. It models the target as a wired-AND on SDA that either follows the master or holds the line low for the whole byte.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 5;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_COND = 2'd1,
    OP_STOP = 2'd2,
    OP_BYTE = 2'd3
  } op_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam logic [1:0] CMD_COND = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;

  localparam int CB_EN   = 0;
  localparam int CB_COND = 3;
  localparam int SB_NAK  = 0;
  localparam int SB_DONE = 3;

  localparam logic [STEP_W-1:0] ACK_STEP = STEP_W'(17);

  function automatic logic [STEP_W-1:0] last_step(op_e op);
    case (op)
      OP_COND: last_step = STEP_W'(3);
      OP_STOP: last_step = STEP_W'(2);
      OP_BYTE: last_step = STEP_W'(18);
      default: last_step = '0;
    endcase
  endfunction

  // Returns {scl_release, sda_release} for a given step
  function automatic logic [1:0] step_lines(op_e op, logic [STEP_W-1:0] s,
                                            logic [BYTE_W-1:0] d);
    case (op)
      OP_COND: begin
        case (s)
          STEP_W'(0): step_lines = 2'b01;
          STEP_W'(1): step_lines = 2'b11;
          STEP_W'(2): step_lines = 2'b10;
          default:    step_lines = 2'b00;
        endcase
      end
      OP_STOP: begin
        case (s)
          STEP_W'(0): step_lines = 2'b00;
          STEP_W'(1): step_lines = 2'b10;
          default:    step_lines = 2'b11;
        endcase
      end
      OP_BYTE: begin
        if (s < STEP_W'(16))   step_lines = {s[0], d[3'd7 - s[3:1]]};
        else if (s == ACK_STEP) step_lines = 2'b11;
        else                   step_lines = 2'b01;
      end
      default: step_lines = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R10: a run of tick-free cycles never exceeds the programmed count
  assert_tick_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $stable(div_i) && (cnt_q == div_i) |-> tick_o);
endmodule

// File: rtl/i2c_bm_seq.sv
module i2c_bm_seq
  import i2c_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic              restart_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              tick_i,
  input  logic              sda_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              nak_set_o,
  output logic              nak_o,
  output logic              scl_rel_o,
  output logic              sda_rel_o
);
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic [BYTE_W-1:0] data_q;
  logic              scl_q, sda_t_q, sda_q, nak_q;
  logic [STEP_W-1:0] first_step, next_step;
  logic [1:0]        first_lines, next_lines;
  logic              at_last;

  assign busy_o      = (op_q != OP_IDLE);
  assign at_last     = (step_q == last_step(op_q));
  assign done_o      = busy_o && tick_i && at_last;
  assign nak_set_o   = (op_q == OP_BYTE) && tick_i && (step_q == ACK_STEP) && sda_i;
  assign first_step  = (op_i == OP_COND && !restart_i) ? STEP_W'(1) : '0;
  assign first_lines = step_lines(op_i, first_step, data_i);
  assign next_step   = step_q + 1'b1;
  assign next_lines  = step_lines(op_q, next_step, data_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      step_q  <= '0;
      data_q  <= '0;
      scl_q   <= 1'b1;
      sda_t_q <= 1'b1;
      sda_q   <= 1'b1;
      nak_q   <= 1'b0;
    end else begin
      sda_q <= sda_t_q;  // SDA trails SCL by one clock
      if (start_i && !busy_o) begin
        op_q    <= op_i;
        step_q  <= first_step;
        data_q  <= data_i;
        scl_q   <= first_lines[1];
        sda_t_q <= first_lines[0];
      end else if (busy_o && tick_i) begin
        if (at_last) begin
          op_q <= OP_IDLE;
        end else begin
          step_q  <= next_step;
          scl_q   <= next_lines[1];
          sda_t_q <= next_lines[0];
        end
      end
      if ((op_q == OP_BYTE) && tick_i && (step_q == ACK_STEP)) nak_q <= sda_i;
    end
  end

  assign nak_o     = nak_q;
  assign scl_rel_o = scl_q;
  assign sda_rel_o = sda_q;

  assert_no_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_sda_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_BYTE) && scl_q && $past(scl_q) |-> $stable(sda_q));
  assert_step_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> step_q <= last_step(op_q));
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o || $past(start_i));
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              nak_set_i,
  input  logic              nak_i,
  output logic              start_o,
  output op_e               op_o,
  output logic              restart_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        status_o
);
  logic       en_q, done_q, nakf_q;
  logic [1:0] cmd_q;
  logic       wr_ctrl, wr_dat, ctrl_go;
  logic [1:0] wr_cmd;
  logic [7:0] clr;

  assign wr_cmd  = wr_data_i[2:1];
  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL) && !busy_i;
  assign wr_dat  = wr_en_i && (wr_sel_i == SEL_DATA) && !busy_i && en_q;
  assign ctrl_go = wr_ctrl && wr_data_i[CB_EN] && (wr_cmd == CMD_COND || wr_cmd == CMD_STOP);
  assign clr     = (wr_en_i && wr_sel_i == SEL_STAT) ? wr_data_i : 8'h00;

  assign start_o   = ctrl_go || wr_dat;
  assign op_o      = wr_dat ? OP_BYTE : (wr_cmd == CMD_STOP ? OP_STOP : OP_COND);
  assign restart_o = wr_data_i[CB_COND];
  assign data_o    = wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cmd_q  <= '0;
      done_q <= 1'b0;
      nakf_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wr_data_i[CB_EN];
        cmd_q <= wr_cmd;
      end
      done_q <= done_i    | (done_q & ~clr[SB_DONE]);
      nakf_q <= nak_set_i | (nakf_q & ~clr[SB_NAK]);
    end
  end

  assign ctrl_o   = {4'b0000, nak_i, cmd_q, en_q};
  assign status_o = {busy_i, 3'b000, done_q, 2'b00, nakf_q};

  assert_done_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> status_o[SB_DONE]);
  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_sel_i == SEL_STAT) && wr_data_i[SB_DONE] && !done_i |=> !status_o[SB_DONE]);
  assert_ctrl_hold_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(ctrl_o[2:0]));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pad_dis_i,
  input  logic             sda_i,
  output logic [7:0]       ctrl_o,
  output logic [7:0]       status_o,
  output logic             scl_drv_n_o,
  output logic             sda_drv_n_o
);
  logic              start, restart, busy, done, nak_set, nak, tick, scl_rel, sda_rel;
  op_e               op;
  logic [BYTE_W-1:0] data;

  i2c_bm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .busy_i(busy), .done_i(done), .nak_set_i(nak_set), .nak_i(nak),
    .start_o(start), .op_o(op), .restart_o(restart), .data_o(data),
    .ctrl_o, .status_o
  );

  i2c_bm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(busy), .div_i, .tick_o(tick)
  );

  i2c_bm_seq u_seq (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .restart_i(restart),
    .data_i(data), .tick_i(tick), .sda_i,
    .busy_o(busy), .done_o(done), .nak_set_o(nak_set), .nak_o(nak),
    .scl_rel_o(scl_rel), .sda_rel_o(sda_rel)
  );

  assign scl_drv_n_o = pad_dis_i | scl_rel;
  assign sda_drv_n_o = pad_dis_i | sda_rel;

  assert_busy_from_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[7]) |-> $past(wr_en_i));
  assert_pad_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_dis_i && $past(pad_dis_i) |-> $stable(scl_drv_n_o) && $stable(sda_drv_n_o));
endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/100ps
module i2c_byte_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] div = 8'd1;
  logic       pad_dis = 1'b0;
  logic       tgt_nak = 1'b1;
  logic [7:0] ctrl_o, status_o;
  logic       scl, sda, sda_line;

  int checks = 0, failures = 0, cyc = 0;
  int rises = 0, starts = 0, stops = 0, busy_cnt = 0;
  logic [8:0] bits = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, seen_low = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda & tgt_nak;  // target holds SDA low when acknowledging

  i2c_byte_master u_i2c_byte_master (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .div_i(div), .pad_dis_i(pad_dis), .sda_i(sda_line),
    .ctrl_o(ctrl_o), .status_o(status_o), .scl_drv_n_o(scl), .sda_drv_n_o(sda)
  );

  always @(negedge clk) begin
    if (scl && !prev_scl) begin rises++; bits = {bits[7:0], sda}; end
    if (scl && prev_scl && prev_sda && !sda) starts++;
    if (scl && prev_scl && !prev_sda && sda) stops++;
    if (!scl || !sda) seen_low = 1'b1;
    if (status_o[7]) busy_cnt++;
    prev_scl = scl;
    prev_sda = sda;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int exp_busy(int steps, int dv);
    return steps * (dv + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk); #1;
    rises = 0; starts = 0; stops = 0; busy_cnt = 0; bits = '0; seen_low = 1'b0;
  endtask

  task automatic issue(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (!status_o[7]) break;
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 lines", {scl, sda}, 2'b11);
    rst_n = 1'b1;

    // R2 enable with no command
    clr_mon();
    issue(2'd0, 8'h01);
    idle_cycles(6);
    chk("R2 ctrl readback", ctrl_o, 8'h01);
    chk("R2 no busy", busy_cnt, 0);

    // R2 command with enable bit clear does nothing
    clr_mon();
    issue(2'd0, 8'h02);
    idle_cycles(6);
    chk("R2 cmd without enable", busy_cnt + rises + starts, 0);

    // R13 data write while disabled
    clr_mon();
    issue(2'd1, 8'h3C);
    idle_cycles(10);
    chk("R13 ignored data", busy_cnt + rises, 0);
    chk("R13 lines idle", {scl, sda}, 2'b11);
    issue(2'd0, 8'h01);

    // R3 start from idle
    div = 8'd2;
    clr_mon();
    issue(2'd0, 8'h03);
    wait_idle();
    chk("R3 start seen", starts, 1);
    chk("R3 no clock", rises, 0);
    chk("R10 start length", busy_cnt, exp_busy(3, 2));
    chk("R7 done flag", status_o, 8'h08);
    chk("R3 lines low", {scl, sda}, 2'b00);
    issue(2'd0, 8'h01);
    issue(2'd2, 8'h08);
    chk("R8 clear done", status_o, 8'h00);

    // R5 R6 random bytes
    for (int k = 0; k < 8; k++) begin
      div = 8'($urandom_range(1, 5));
      tgt_nak = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      if (k == 0) d = 8'h80;
      if (k == 1) d = 8'h01;
      clr_mon();
      issue(2'd1, d);
      wait_idle();
      chk("R5 bits", bits, {d, 1'b1});
      chk("R5 clocks", rises, 9);
      chk("R11 no cond in byte", starts + stops, 0);
      chk("R10 byte length", busy_cnt, exp_busy(19, int'(div)));
      chk("R6 ctrl ack bit", ctrl_o[3], tgt_nak);
      chk("R6 nak flag", status_o[0], tgt_nak);
      chk("R7 done", status_o[3], 1);
      chk("R5 hold scl low", {scl, sda}, 2'b01);
      issue(2'd2, 8'h08);
      chk("R8 partial clear", status_o, {7'd0, tgt_nak});
      issue(2'd2, 8'h01);
      chk("R8 full clear", status_o, 0);
    end

    // R9 writes while busy
    div = 8'd3;
    tgt_nak = 1'b0;
    clr_mon();
    issue(2'd1, 8'hA5);
    issue(2'd0, 8'h05);
    issue(2'd1, 8'h5A);
    wait_idle();
    chk("R9 byte intact", bits, {8'hA5, 1'b1});
    chk("R9 no stop", stops, 0);
    chk("R9 length", busy_cnt, exp_busy(19, 3));
    chk("R9 ctrl unchanged", ctrl_o, 8'h01);
    issue(2'd2, 8'hFF);

    // R3 repeated start
    div = 8'd1;
    clr_mon();
    issue(2'd0, 8'h0B);
    wait_idle();
    chk("R3 restart clock", rises, 1);
    chk("R3 restart cond", starts, 1);
    chk("R3 restart length", busy_cnt, exp_busy(4, 1));
    issue(2'd0, 8'h01);
    issue(2'd2, 8'hFF);

    // R4 stop
    div = 8'd4;
    clr_mon();
    issue(2'd0, 8'h05);
    wait_idle();
    chk("R4 stop cond", stops, 1);
    chk("R4 stop clock", rises, 1);
    chk("R4 stop length", busy_cnt, exp_busy(3, 4));
    chk("R4 lines released", {scl, sda}, 2'b11);
    issue(2'd0, 8'h01);
    issue(2'd2, 8'hFF);

    // R2 reserved command
    clr_mon();
    issue(2'd0, 8'h07);
    idle_cycles(8);
    chk("R2 reserved cmd", busy_cnt, 0);
    issue(2'd0, 8'h01);

    // R12 pad disable
    pad_dis = 1'b1;
    clr_mon();
    issue(2'd0, 8'h03);
    wait_idle();
    chk("R12 no drive", seen_low, 0);
    chk("R12 op ran", status_o[3], 1);
    pad_dis = 1'b0;
    idle_cycles(1);
    chk("R12 drive resumes", {scl, sda}, 2'b00);
    issue(2'd0, 8'h01);
    issue(2'd0, 8'h05);
    wait_idle();
    chk("R4 cleanup stop", {scl, sda}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule